// File: doc/BRIEF.md
# Barrel Shifter with Carry Out

This block is a purely combinational word shifter for an integer datapath. It takes an operand word, a shift kind, a shift count and the incoming carry flag. It returns the shifted word, the carry-out produced by the shift, and the value the carry flag should take next. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-position rotate right that passes through the carry flag.

The count comes from one of two sources. One is a small immediate field. The other is a register word, of which only the low byte is used, so counts from 0 to 255 are possible. Every count has a defined result and carry-out, including counts equal to or larger than the word width. The next carry flag follows the shift's carry-out only when the flag-setting variant is requested. Otherwise the flag keeps its incoming value.

Top module: `bshift_carry`

## Requirements
- R1: Kind encoding on `kind_i` is 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right through carry. For kinds 0 to 3, a count of 0 returns `data_i` unchanged with `carry_o` equal to `carry_i`. Codes 5, 6 and 7 always pass `data_i` and `carry_i` through unchanged.
- R2: When `amt_sel_i` is 1, the count is `amt_reg_i[7:0]` and bits above 7 have no effect. When it is 0, the count is the 6-bit `amt_imm_i` (0 to 63), zero-extended.
- R3: Logical left by n in 1..32 gives `data_i << n`, and the carry-out is the last bit shifted out, `data_i[32-n]`. For n above 32, the result and the carry-out are both 0.
- R4: Logical right by n in 1..32 gives `data_i >> n` with carry-out `data_i[n-1]`. For n above 32, the result and the carry-out are both 0.
- R5: Arithmetic right by n in 1..31 copies bit 31 into the vacated bits, and the carry-out is `data_i[n-1]`. For n of 32 or more, including an immediate count of 32, every result bit and the carry-out equal `data_i[31]`.
- R6: Rotate right by a nonzero n rotates by n modulo 32, and the carry-out equals bit 31 of the result. A nonzero multiple of 32 leaves the word unchanged but still sets the carry-out to `data_i[31]`.
- R7: Rotate through carry ignores the count. The result is `{carry_i, data_i[31:1]}` and the carry-out is `data_i[0]`.
- R8: `carry_flag_o` equals `carry_o` when `set_flags_i` is 1 and equals `carry_i` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Operand word to shift |
| kind_i | input | 3 | Shift kind code |
| amt_sel_i | input | 1 | 1: count from register low byte, 0: from immediate |
| amt_imm_i | input | 6 | Immediate shift count |
| amt_reg_i | input | 32 | Register word supplying the count |
| carry_i | input | 1 | Incoming carry flag |
| set_flags_i | input | 1 | Flag-setting variant selected |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry-out of the shift |
| carry_flag_o | output | 1 | Next value of the carry flag |

## Verification
Each kind is swept over all 256 register counts. The operands are all-zero, all-one, lone-top-bit, lone-low-bit, alternating patterns and random words. The sign-bit patterns separate arithmetic from logical right shifts. The lone-bit patterns expose any off-by-one in the carry-out bit index at 1, 31, 32 and 33. The immediate path is swept over 0 to 63 with noise in the unused register bits, which shows that the source select and the byte truncation behave as required. Random incoming carry and flag-set values check the carry-flag selection and the carry insertion of the one-position rotate.

// File: rtl/bshift_carry.sv
module bshift_carry #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 6,
  parameter int CNT_W = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [2:0]       kind_i,
  input  logic             amt_sel_i,
  input  logic [IMM_W-1:0] amt_imm_i,
  input  logic [WIDTH-1:0] amt_reg_i,
  input  logic             carry_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_flag_o
);
  localparam int RW = $clog2(WIDTH);
  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic [CNT_W-1:0]   cnt;
  logic [WIDTH:0]     lsl_x, lsr_x, asr_x;
  logic [RW-1:0]      rot;
  logic [2*WIDTH-1:0] ror_x;
  logic [WIDTH-1:0]   ror_v;
  logic               unused_bits;

  assign cnt   = amt_sel_i ? amt_reg_i[CNT_W-1:0] : CNT_W'(amt_imm_i);
  assign lsl_x = {1'b0, data_i} << cnt;
  assign lsr_x = {data_i, 1'b0} >> cnt;
  assign asr_x = $signed({data_i, 1'b0}) >>> cnt;
  assign rot   = cnt[RW-1:0];
  assign ror_x = {data_i, data_i} >> rot;
  assign ror_v = ror_x[WIDTH-1:0];
  assign unused_bits = ^{amt_reg_i[WIDTH-1:CNT_W], ror_x[2*WIDTH-1:WIDTH]};

  always_comb begin
    result_o = data_i;
    carry_o  = carry_i;
    case (kind_i)
      K_LSL: if (cnt != '0) {carry_o, result_o} = lsl_x;
      K_LSR: if (cnt != '0) {result_o, carry_o} = lsr_x;
      K_ASR: if (cnt != '0) {result_o, carry_o} = asr_x;
      K_ROR: if (cnt != '0) begin
        result_o = ror_v;
        carry_o  = ror_v[WIDTH-1];
      end
      K_RRX: begin
        result_o = {carry_i, data_i[WIDTH-1:1]};
        carry_o  = data_i[0];
      end
      default: ;
    endcase
  end

  assign carry_flag_o = set_flags_i ? carry_o : carry_i;
endmodule

module bshift_carry_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 6,
  parameter int CNT_W = 8
) (
  input logic [WIDTH-1:0] data_i,
  input logic [2:0]       kind_i,
  input logic             amt_sel_i,
  input logic [IMM_W-1:0] amt_imm_i,
  input logic [WIDTH-1:0] amt_reg_i,
  input logic             carry_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             carry_flag_o
);
  logic [CNT_W-1:0] n;
  logic             known;
  assign n = amt_sel_i ? amt_reg_i[CNT_W-1:0] : CNT_W'(amt_imm_i);
  assign known = !$isunknown({data_i, kind_i, amt_sel_i, amt_imm_i, amt_reg_i,
                              carry_i, set_flags_i, result_o, carry_o, carry_flag_o});

  always_comb begin
    if (known) begin
      if (kind_i <= 3'd3 && n == '0)
        assert_zero_count_R1: assert (result_o == data_i && carry_o == carry_i);
      if (kind_i >= 3'd5)
        assert_idle_code_R1: assert (result_o == data_i && carry_o == carry_i);
      if (kind_i <= 3'd1 && int'(n) > WIDTH)
        assert_overshift_clear_R3: assert (result_o == '0 && carry_o == 1'b0);
      if (kind_i == 3'd2 && int'(n) >= WIDTH)
        assert_sign_fill_R5: assert (result_o == {WIDTH{data_i[WIDTH-1]}} && carry_o == data_i[WIDTH-1]);
      if (kind_i == 3'd3 && n != '0)
        assert_rot_carry_R6: assert (carry_o == result_o[WIDTH-1]);
      if (kind_i == 3'd4)
        assert_rrx_R7: assert (result_o[WIDTH-1] == carry_i && carry_o == data_i[0]);
      assert_flag_sel_R8: assert (carry_flag_o == (set_flags_i ? carry_o : carry_i));
    end
  end
endmodule

bind bshift_carry bshift_carry_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_bshift_carry.sv
module test_bshift_carry;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] data_i = '0;
  logic [2:0]  kind_i = '0;
  logic        amt_sel_i = 1'b0;
  logic [5:0]  amt_imm_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic        set_flags_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, carry_flag_o;
  int          errors = 0;
  int          checks = 0;
  logic [31:0] pats [12];

  bshift_carry i_bshift_carry (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s kind=%0d data=%h cnt=%0d sel=%0b: got %h expected %h",
               tag, kind_i, data_i, amt_sel_i ? amt_reg_i[7:0] : {2'b0, amt_imm_i},
               amt_sel_i, got, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input int k, input logic [31:0] d, input int n, input logic ci,
                       output logic [31:0] r, output logic co);
    r = d;
    co = ci;
    if (k == 4) begin
      co = d[0];
      r = {ci, d[31:1]};
    end else if (k <= 3) begin
      for (int s = 0; s < n; s++) begin
        case (k)
          0: begin co = r[31]; r = {r[30:0], 1'b0}; end
          1: begin co = r[0];  r = {1'b0, r[31:1]}; end
          2: begin co = r[0];  r = {r[31], r[31:1]}; end
          default: begin co = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
  endtask

  task automatic apply_and_check(input string tag, input int k, input int n);
    logic [31:0] er;
    logic        ec;
    #2;
    model(k, data_i, n, carry_i, er, ec);
    chk(tag, result_o, er);
    chk(tag, {31'b0, carry_o}, {31'b0, ec});
    chk("R8", {31'b0, carry_flag_o}, {31'b0, set_flags_i ? ec : carry_i});
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pats = '{32'h0, 32'hFFFFFFFF, 32'h80000000, 32'h00000001, 32'hAAAAAAAA,
             32'h55555555, 32'h7FFFFFFF, 32'h80000001, 32'h0, 32'h0, 32'h0, 32'h0};
    for (int i = 8; i < 12; i++) pats[i] = $urandom;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", result_o, 32'h0);
    chk("R1", {31'b0, carry_o}, 32'h0);
    chk("R8", {31'b0, carry_flag_o}, 32'h0);
    rst = 1'b0;

    amt_sel_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 12; p++) begin
        for (int n = 0; n < 256; n++) begin
          kind_i      = 3'(k);
          data_i      = pats[p];
          amt_reg_i   = {$urandom_range(0, 16777215), 8'(n)};
          carry_i     = 1'($urandom);
          set_flags_i = 1'($urandom);
          amt_imm_i   = 6'($urandom);
          apply_and_check(tag_of(k), k, n);
        end
      end
    end

    amt_sel_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      for (int p = 0; p < 12; p++) begin
        for (int n = 0; n < 64; n++) begin
          kind_i      = 3'(k);
          data_i      = pats[p];
          amt_imm_i   = 6'(n);
          amt_reg_i   = $urandom;
          carry_i     = 1'($urandom);
          set_flags_i = 1'($urandom);
          apply_and_check("R2", k, n);
        end
      end
    end

    amt_sel_i = 1'b0;
    kind_i    = 3'd2;
    amt_imm_i = 6'd32;
    data_i    = 32'h80000000;
    carry_i   = 1'b0;
    set_flags_i = 1'b1;
    #2;
    chk("R5", result_o, 32'hFFFFFFFF);
    chk("R5", {31'b0, carry_o}, 32'h1);
    chk("R8", {31'b0, carry_flag_o}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule